// File: doc/BRIEF.md
# SPI Command Target with Chained Framing

This block is the serial front end of a register-controlled converter. A host drives chip select (`cs_n`), serial clock (`sclk`) and serial data (`sdi`). Every command is a 24-bit word. The upper byte is a register address and the lower 16 bits are data. An accepted word is committed to a small register file on the rising edge of `cs_n`. The block has no free-running clock: every flop is clocked by an `sclk` edge or a `cs_n` edge, so nothing toggles between frames.

Two framing modes exist, and a configuration bit in the register file selects between them.

- **Stand-alone mode:** the first 24 bits of a frame are decoded. The frame may run to any length of 24 clocks or more.
- **Chained mode:** the total clock count must be an exact multiple of 24, and the last 24 bits are decoded. Earlier bits leave on `sdo` 24 clocks after they arrived, so a downstream device on the same chip select receives them.

A frame framer tracks the bit position with a small state machine clocked by falling `sclk` edges. Its states are:

- `ST_EMPTY`: no bit yet in this frame.
- `ST_FILL`: fewer than 24 bits received.
- `ST_WORD`: the count is a non-zero multiple of 24.
- `ST_PART`: past the first word and not on a word boundary.

Its transitions are:

- fill-start: `ST_EMPTY` to `ST_FILL`, on the first bit.
- word-done: `ST_FILL` or `ST_PART` to `ST_WORD`, on the bit that completes a word.
- word-break: `ST_WORD` to `ST_PART`, on the next bit.
- frame-reset: any state to `ST_EMPTY`, whenever `cs_n` is high.

Top module: `spi_dc_target`

## Requirements
- R1: A committed word writes its lower 16 bits to channel register i when its upper byte equals 0x18+i (i = 0..3). Channel i appears on `chan_code[16*i+15:16*i]`. The first bit shifted in is word bit 23.
- R2: In stand-alone mode, a frame of 24 or more falling `sclk` edges commits the first 24 bits received, whatever the total length.
- R3: In stand-alone mode, a frame of fewer than 24 falling edges changes no register.
- R4: A committed word whose address is neither 0x03 nor 0x18..0x1B changes no register.
- R5: A committed word with address 0x03 copies its data bit 0 into `chain_mode`. The new mode governs the frames that follow.
- R6: In chained mode, a frame of exactly 24×N falling edges (N ≥ 1) commits the last 24 bits received.
- R7: In chained mode, a frame whose edge count is not a non-zero multiple of 24 changes no register.
- R8: In chained mode, `sdo` during clock k of a frame carries the `sdi` bit of clock k−24 for k > 24, and carries 0 for k ≤ 24. The bit changes on the rising `sclk` edge, and no bit from an earlier frame ever appears.
- R9: `sdo_oe` is 1 only while `cs_n` is low and `chain_mode` is 1.
- R10: Registers and `chain_mode` change only on a rising `cs_n` edge and never while a frame is in progress.
- R11: Frames behave identically whether `sclk` idles high or low around `cs_n`.
- R12: After `rst_n` is asserted, all channel registers and `chain_mode` are 0.
- R13: Chained frames far longer than one word (five words) still commit only their final word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous power-on reset of the register file, active low |
| cs_n | input | 1 | Chip select, active low; a rising edge commits the frame |
| sclk | input | 1 | Serial clock; `sdi` is sampled on the falling edge |
| sdi | input | 1 | Serial data in, MSB of each word first |
| sdo | output | 1 | Serial data out, the input delayed by 24 clocks |
| sdo_oe | output | 1 | Output enable for `sdo`; `sdo` is high-impedance when 0 |
| chain_mode | output | 1 | Configuration bit selecting chained framing |
| chan_code | output | 64 | Four 16-bit channel registers, channel 0 in the low bits |

## Verification
The bench builds the block with its default parameters: 8-bit address, 16-bit data, four channels, configuration address 0x03 and channel base 0x18. These values let a frame of one to five words, both `sclk` idle levels, and both framing modes all be reached in a few thousand cycles. Random frame lengths are drawn around the word boundaries (23, 24, 25, 47, 48, 49 and up to 120 bits), with random mode switches. This exercises acceptance, rejection, first-word versus last-word selection and the 24-clock `sdo` delay against a bench model of the register file.

// File: rtl/spi_dc_pkg.sv
package spi_dc_pkg;

    // Frame position as seen by the framer, advanced on falling sclk edges
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,   // no bit received in this frame
        ST_FILL  = 2'd1,   // fewer than one full word received
        ST_WORD  = 2'd2,   // bit count is a non-zero multiple of the word length
        ST_PART  = 2'd3    // past the first word, not on a word boundary
    } frame_st_t;

endpackage

// File: rtl/spi_dc_shifter.sv
module spi_dc_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              shift_en,
    output logic [WORD_W-1:0] word_q,
    output logic              sdo_q
);

    logic [WORD_W-1:0] sr_q;

    // Capture on the falling edge; cleared while the target is deselected
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[WORD_W-2:0], sdi};
        end
    end

    // Launch the bit leaving the word register on the rising edge
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            sdo_q <= 1'b0;
        end else begin
            sdo_q <= sr_q[WORD_W-1];
        end
    end

    assign word_q = sr_q;

endmodule

// File: rtl/spi_dc_framer.sv
module spi_dc_framer
    import spi_dc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic cs_n,
    input  logic sclk,
    input  logic chain_mode,
    output logic shift_en,
    output logic cmd_valid
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    frame_st_t       st_q;
    frame_st_t       st_nx;
    logic [CNT_W-1:0] bit_q;
    logic            wrap;

    assign wrap = (bit_q == LAST_BIT);

    // Modulo-word bit position inside the frame
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            bit_q <= '0;
        end else if (wrap) begin
            bit_q <= '0;
        end else begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // State register
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_EMPTY: st_nx = wrap ? ST_WORD : ST_FILL;
            ST_FILL:  st_nx = wrap ? ST_WORD : ST_FILL;
            ST_WORD:  st_nx = ST_PART;
            ST_PART:  st_nx = wrap ? ST_WORD : ST_PART;
            default:  st_nx = ST_EMPTY;
        endcase
    end

    // Outputs: shifting and acceptance depend on state and mode
    always_comb begin
        shift_en  = 1'b0;
        cmd_valid = 1'b0;
        unique case (st_q)
            ST_EMPTY: begin
                shift_en  = 1'b1;
                cmd_valid = 1'b0;
            end
            ST_FILL: begin
                shift_en  = 1'b1;
                cmd_valid = 1'b0;
            end
            ST_WORD: begin
                shift_en  = chain_mode;
                cmd_valid = 1'b1;
            end
            ST_PART: begin
                shift_en  = chain_mode;
                cmd_valid = !chain_mode;
            end
            default: begin
                shift_en  = 1'b0;
                cmd_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spi_dc_regfile.sv
module spi_dc_regfile #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 16,
    parameter int          N_CH     = 4,
    parameter int          CFG_BIT  = 0,
    parameter logic [7:0]  CFG_ADDR = 8'h03,
    parameter logic [7:0]  CH_BASE  = 8'h18
) (
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     cmd_valid,
    input  logic [ADDR_W+DATA_W-1:0] cmd_word,
    output logic                     chain_mode,
    output logic [N_CH*DATA_W-1:0]   chan_code
);

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    assign addr = cmd_word[ADDR_W+DATA_W-1:DATA_W];
    assign data = cmd_word[DATA_W-1:0];

    // Interface configuration: chained framing enable
    always_ff @(posedge cs_n or negedge rst_n) begin
        if (!rst_n) begin
            chain_mode <= 1'b0;
        end else if (cmd_valid && (addr == ADDR_W'(CFG_ADDR))) begin
            chain_mode <= data[CFG_BIT];
        end
    end

    // One code register per channel
    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CH_BASE) + ADDR_W'(gi);
        logic [DATA_W-1:0] code_q;

        always_ff @(posedge cs_n or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= '0;
            end else if (cmd_valid && (addr == MY_ADDR)) begin
                code_q <= data;
            end
        end

        assign chan_code[gi*DATA_W +: DATA_W] = code_q;
    end

endmodule

// File: rtl/spi_dc_target.sv
module spi_dc_target #(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16,
    parameter int         N_CH     = 4,
    parameter int         CFG_BIT  = 0,
    parameter logic [7:0] CFG_ADDR = 8'h03,
    parameter logic [7:0] CH_BASE  = 8'h18
) (
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic                   sdi,
    output logic                   sdo,
    output logic                   sdo_oe,
    output logic                   chain_mode,
    output logic [N_CH*DATA_W-1:0] chan_code
);

    localparam int WORD_W = ADDR_W + DATA_W;

    logic              shift_en;
    logic              cmd_valid;
    logic [WORD_W-1:0] word_q;
    logic              sdo_q;

    spi_dc_framer #(
        .WORD_W (WORD_W)
    ) u_framer (
        .cs_n       (cs_n),
        .sclk       (sclk),
        .chain_mode (chain_mode),
        .shift_en   (shift_en),
        .cmd_valid  (cmd_valid)
    );

    spi_dc_shifter #(
        .WORD_W (WORD_W)
    ) u_shifter (
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .shift_en (shift_en),
        .word_q   (word_q),
        .sdo_q    (sdo_q)
    );

    spi_dc_regfile #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .N_CH     (N_CH),
        .CFG_BIT  (CFG_BIT),
        .CFG_ADDR (CFG_ADDR),
        .CH_BASE  (CH_BASE)
    ) u_regs (
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .cmd_valid  (cmd_valid),
        .cmd_word   (word_q),
        .chain_mode (chain_mode),
        .chan_code  (chan_code)
    );

    assign sdo    = sdo_q;
    assign sdo_oe = !cs_n && chain_mode;

endmodule

// File: rtl/spi_dc_target_chk.sv
module spi_dc_target_chk #(
    parameter int WORD_W = 24,
    parameter int CH_W   = 64
) (
    input logic            rst_n,
    input logic            cs_n,
    input logic            sclk,
    input logic            sdi,
    input logic            sdo,
    input logic            chain_mode,
    input logic [CH_W-1:0] chan_code
);

    logic [15:0]       seen_q;
    logic [WORD_W-1:0] hist_q;

    // Independent record of edges and bits seen in the current frame
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            seen_q <= '0;
            hist_q <= '0;
        end else begin
            if (seen_q != 16'hFFFF) begin
                seen_q <= seen_q + 16'd1;
            end
            hist_q <= {hist_q[WORD_W-2:0], sdi};
        end
    end

    // R8
    sdo_quiet_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
        (seen_q < 16'(WORD_W)) |-> (sdo == 1'b0));

    // R8
    sdo_delay_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
        (chain_mode && (seen_q >= 16'(WORD_W))) |-> (sdo == hist_q[WORD_W-1]));

    // R10
    chan_hold_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
        (seen_q != 16'd0) |-> $stable(chan_code));

    // R10
    mode_hold_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
        (seen_q != 16'd0) |-> $stable(chain_mode));

endmodule

bind spi_dc_target spi_dc_target_chk #(
    .WORD_W (ADDR_W + DATA_W),
    .CH_W   (N_CH * DATA_W)
) u_chk (
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .sdi        (sdi),
    .sdo        (sdo),
    .chain_mode (chain_mode),
    .chan_code  (chan_code)
);

// File: tb/test_spi_dc_target.sv
`timescale 1ns/100ps
module test_spi_dc_target;

    logic        rst_n = 1'b0;
    logic        cs_n  = 1'b1;
    logic        sclk  = 1'b0;
    logic        sdi   = 1'b0;
    logic        sdo;
    logic        sdo_oe;
    logic        chain_mode;
    logic [63:0] chan_code;

    int n_chk  = 0;
    int n_fail = 0;

    logic        fb [0:199];
    logic        m_mode = 1'b0;
    logic [63:0] m_ch   = '0;

    spi_dc_target i_spi_dc_target (
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .chain_mode (chain_mode),
        .chan_code  (chan_code)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void decode(input logic [23:0] w);
        if (w[23:16] == 8'h03) begin
            m_mode = w[0];
        end else if (w[23:16] >= 8'h18 && w[23:16] <= 8'h1B) begin
            m_ch[(int'(w[23:16]) - 24) * 16 +: 16] = w[15:0];
        end
    endfunction

    // Reference acceptance rule, applied on the mode in force for the frame
    function automatic void model_frame(input int n);
        logic [23:0] w;
        w = '0;
        if (!m_mode) begin
            if (n >= 24) begin
                for (int i = 0; i < 24; i++) w[23-i] = fb[i];
                decode(w);
            end
        end else if (n >= 24 && (n % 24) == 0) begin
            for (int i = 0; i < 24; i++) w[23-i] = fb[n-24+i];
            decode(w);
        end
    endfunction

    task automatic build(input int n, input bit last, input logic [23:0] w);
        for (int i = 0; i < 200; i++) fb[i] = 1'($urandom);
        if (n >= 24) begin
            for (int i = 0; i < 24; i++) begin
                if (last) fb[n-24+i] = w[23-i];
                else      fb[i]      = w[23-i];
            end
        end
    endtask

    task automatic run_frame(input int n, input bit idle_hi, input string tag);
        logic [63:0] pre_ch;
        logic        pre_mode;
        logic        exp_b;
        int          sdo_bad;
        int          oe_bad;
        bit          mid_bad;
        pre_ch   = chan_code;
        pre_mode = chain_mode;
        sdo_bad  = 0;
        oe_bad   = 0;
        mid_bad  = 0;
        sclk = idle_hi;
        #4;
        cs_n = 1'b0;
        #4;
        for (int k = 1; k <= n; k++) begin
            sdi = fb[k-1];
            if (idle_hi) #0.5;
            else begin #1 sclk = 1'b1; #1.5; end
            exp_b = (k > 24) ? fb[k-25] : 1'b0;
            if (m_mode && sdo !== exp_b) sdo_bad++;
            if (sdo_oe !== m_mode) oe_bad++;
            if (chan_code !== pre_ch || chain_mode !== pre_mode) mid_bad = 1;
            if (idle_hi) begin #0.5 sclk = 1'b0; #2 sclk = 1'b1; #1; end
            else begin #0.5 sclk = 1'b0; #1; end
        end
        #1 cs_n = 1'b1;
        sdi = 1'b0;
        #4;
        if (m_mode) chk(sdo_bad == 0, "R8 sdo delayed stream", 64'(sdo_bad), 64'd0);
        chk(oe_bad == 0, "R9 sdo_oe in frame", 64'(oe_bad), 64'd0);
        chk(!mid_bad, "R10 no change mid-frame", 64'(mid_bad), 64'd0);
        model_frame(n);
        chk(sdo_oe === 1'b0, "R9 sdo_oe after frame", 64'(sdo_oe), 64'd0);
        chk(chain_mode === m_mode, {tag, " mode"}, 64'(chain_mode), 64'(m_mode));
        chk(chan_code === m_ch, {tag, " channels"}, chan_code, m_ch);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int lens [11] = '{8, 23, 24, 25, 37, 47, 48, 49, 72, 96, 120};
        void'($urandom(32'h1234_5eed));
        #10;
        // R12 reset state
        chk(chan_code === 64'd0, "R12 channels at reset", chan_code, 64'd0);
        chk(chain_mode === 1'b0, "R12 mode at reset", 64'(chain_mode), 64'd0);
        chk(sdo_oe === 1'b0, "R9 sdo_oe at reset", 64'(sdo_oe), 64'd0);
        rst_n = 1'b1;
        #10;

        build(24, 0, 24'h18_A5C3); run_frame(24, 0, "R1 write ch0");
        build(24, 0, 24'h1B_0F0F); run_frame(24, 0, "R1 write ch3");
        build(37, 0, 24'h19_1234); run_frame(37, 0, "R2 first word of 37");
        build(23, 0, 24'h1A_FFFF); run_frame(23, 0, "R3 short frame");
        build(24, 0, 24'h40_BEEF); run_frame(24, 0, "R4 undefined addr");
        build(24, 0, 24'h02_FFFF); run_frame(24, 0, "R4 undefined addr");
        build(30, 0, 24'h1A_7777); run_frame(30, 1, "R11 idle high stand-alone");
        build(24, 0, 24'h03_0001); run_frame(24, 0, "R5 enter chained");
        build(48, 1, 24'h19_4321); run_frame(48, 0, "R6 last word of 48");
        build(49, 1, 24'h18_DEAD); run_frame(49, 0, "R7 misaligned 49");
        build(23, 1, 24'h18_DEAD); run_frame(23, 0, "R7 short 23");
        build(24, 1, 24'h1A_C0DE); run_frame(24, 1, "R11 idle high chained");
        build(120, 1, 24'h1B_55AA); run_frame(120, 0, "R13 five words");
        build(72, 1, 24'h03_0000); run_frame(72, 1, "R5 leave chained");
        build(48, 1, 24'h18_1111); run_frame(48, 0, "R2 stand-alone after leave");

        for (int t = 0; t < 60; t++) begin
            int          n;
            int          pick;
            logic [23:0] w;
            string       tag;
            n    = lens[$urandom % 11];
            pick = int'($urandom % 8);
            w[15:0] = 16'($urandom);
            if (pick < 4)       w[23:16] = 8'h18 + 8'(pick);
            else if (pick == 4) w[23:16] = 8'h03;
            else                w[23:16] = 8'($urandom);
            build(n, m_mode, w);
            if (!m_mode) tag = (n < 24) ? "R3 random" : "R2 random";
            else         tag = ((n % 24) == 0) ? "R6 random" : "R7 random";
            run_frame(n, 1'($urandom), tag);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule